// File: doc/BRIEF.md
# Crossing-Indexed Triggered Latency Buffer

This block keeps the recent history of a detector front end, organised by beam crossing rather than by arrival time. Each incoming hit carries the 6-bit crossing number it belongs to and is appended to the storage slot for that crossing. There are 64 slots, one for each value of the crossing counter. A slot is reset to empty when the running crossing counter moves onto its number. Hits therefore stay available for about 64 crossings, which gives the level-1 trigger that long to decide.

When a trigger names a crossing, the block reads that slot and emits a framed packet of 20-bit words. The packet is a header, then the stored hits in arrival order, then a trailer that carries the hit count and flags for overflow and truncation. Triggers that arrive while a packet is still being sent wait in a short queue. The output side uses valid/ready flow control.

Top module: `xing_trig_buffer`

## Requirements
- R1: A hit accepted with tag T is appended to slot T. The hits of a slot leave in the packet in the order they arrived.
- R2: A slot holds at most SLOT_HITS hits (default 16). Further hits for a full slot are discarded, and the slot's sticky overflow flag is set. The flag appears as trailer bit 15.
- R3: When cur_xing changes to value V, slot V's count and overflow flag are cleared. A hit for V presented in that same cycle is kept as the slot's first entry.
- R4: A trigger for crossing X produces one packet with three parts:
  - a header {4'hA, zeros, X[5:0]}, flagged with out_sop;
  - the hits sent from slot X;
  - a trailer {4'hF, ovf(bit 15), trunc(bit 14), zeros, count[5:0]}, flagged with out_eop, where count is the number of hits held in the slot.
  An empty slot gives a header followed directly by the trailer.
- R5: A packet never exceeds PKT_MAX_WORDS words (default 2000). If a slot holds more than PKT_MAX_WORDS-2 hits, only the first PKT_MAX_WORDS-2 are sent and trailer bit 14 is set.
- R6: Up to TQ_DEPTH (default 4) triggers wait in a queue and are served in arrival order. A trigger that arrives while the queue is full is discarded, and trig_drop_cnt increments.
- R7: While out_valid is high and out_ready is low, out_data, out_sop and out_eop hold their values. Every word is delivered exactly once.
- R8: After reset, out_valid and trig_drop_cnt are 0, every slot is empty, and hit_ready is 1 from the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_xing | input | 6 | Running beam-crossing counter |
| hit_valid | input | 1 | Hit word present |
| hit_ready | output | 1 | Hit input accepts words (high out of reset) |
| hit_xing | input | 6 | Crossing tag carried by the hit |
| hit_data | input | 20 | Hit payload |
| trig_valid | input | 1 | Level-1 trigger pulse |
| trig_xing | input | 6 | Crossing requested by the trigger |
| out_valid | output | 1 | Output word present |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 20 | Packet word |
| out_sop | output | 1 | Word is a packet header |
| out_eop | output | 1 | Word is a packet trailer |
| trig_drop_cnt | output | 8 | Triggers discarded on a full queue |

## Verification
Two events can land on the same slot in the same cycle: the crossing counter stepping onto a value, and a hit tagged with that value. The bench provokes this after a full wrap of the counter. It drives the new cur_xing together with a matching hit onto a slot that still holds older hits. It then expects the triggered packet to contain only that single hit, with a count of one. A trigger can also arrive while the builder is busy. To exercise this, the bench stalls the output and issues queue-depth-plus-two triggers. It then judges the discard counter and the order of the packets that follow.

// File: rtl/xtb_pkg.sv
package xtb_pkg;
  typedef enum logic [1:0] {B_IDLE, B_HDR, B_HITS, B_TRL} bstate_e;
  localparam logic [3:0] HDR_TAG = 4'hA;
  localparam logic [3:0] TRL_TAG = 4'hF;
endpackage

// File: rtl/xtb_slot_store.sv
module xtb_slot_store #(
  parameter int XW        = 6,
  parameter int SLOT_HITS = 16,
  parameter int WORD_W    = 20,
  localparam int IW       = $clog2(SLOT_HITS),
  localparam int CW       = $clog2(SLOT_HITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [XW-1:0]     cur_xing,
  input  logic              hit_valid,
  output logic              hit_ready,
  input  logic [XW-1:0]     hit_xing,
  input  logic [WORD_W-1:0] hit_data,
  input  logic [XW-1:0]     rd_xing,
  input  logic [IW-1:0]     rd_idx,
  output logic [WORD_W-1:0] rd_word,
  output logic [CW-1:0]     rd_cnt,
  output logic              rd_ovf
);
  localparam int NSLOT = 1 << XW;
  localparam logic [CW-1:0] FULL = CW'(SLOT_HITS);

  logic [WORD_W-1:0] mem [NSLOT*SLOT_HITS];
  logic [CW-1:0]     cnt_q [NSLOT];
  logic [NSLOT-1:0]  ovf_q;
  logic [XW-1:0]     prev_xing;
  logic              rdy_q;
  logic              adv, adv_same, take, wr_ok;
  logic [CW-1:0]     base;

  always_comb begin
    adv      = cur_xing != prev_xing;
    adv_same = adv && (hit_xing == cur_xing);
    base     = adv_same ? '0 : cnt_q[hit_xing];
    take     = hit_valid && rdy_q;
    wr_ok    = take && (base < FULL);
  end

  assign hit_ready = rdy_q;
  assign rd_word   = mem[{rd_xing, rd_idx}];
  assign rd_cnt    = cnt_q[rd_xing];
  assign rd_ovf    = ovf_q[rd_xing];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[{hit_xing, base[IW-1:0]}] <= hit_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSLOT; i++) cnt_q[i] <= '0;
      ovf_q     <= '0;
      prev_xing <= '0;
      rdy_q     <= 1'b0;
    end else begin
      rdy_q     <= 1'b1;
      prev_xing <= cur_xing;
      if (adv) begin
        cnt_q[cur_xing] <= '0;
        ovf_q[cur_xing] <= 1'b0;
      end
      if (take) begin
        if (base < FULL) cnt_q[hit_xing] <= base + 1'b1;
        else             ovf_q[hit_xing] <= 1'b1;
      end
    end
  end

  // R2: a hit into a full slot leaves it full and flags overflow
  a_r2_full_drop: assert property (@(posedge clk) disable iff (rst)
    (take && !adv_same && cnt_q[hit_xing] == FULL) |=>
      (cnt_q[$past(hit_xing)] == FULL && ovf_q[$past(hit_xing)]));

  // R3: stepping onto a slot leaves it holding at most the same-cycle hit
  a_r3_clear_on_step: assert property (@(posedge clk) disable iff (rst)
    adv |=> (cnt_q[$past(cur_xing)] <= CW'(1)));

  // R2: count never exceeds slot capacity
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    rd_cnt <= FULL);
endmodule

// File: rtl/xtb_trig_fifo.sv
module xtb_trig_fifo #(
  parameter int DEPTH  = 4,
  parameter int W      = 6,
  parameter int DROP_W = 8,
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [W-1:0]      din,
  input  logic              pop,
  output logic              empty,
  output logic [W-1:0]      head,
  output logic [DROP_W-1:0] drop_cnt
);
  logic [W-1:0]  q [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   n;
  logic          full, acc, deq;

  always_comb begin
    full  = n == (PW+1)'(DEPTH);
    empty = n == '0;
    acc   = push && !full;
    deq   = pop && !empty;
    head  = q[rp];
  end

  always_ff @(posedge clk) begin
    if (acc) q[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0; rp <= '0; n <= '0; drop_cnt <= '0;
    end else begin
      if (acc) wp <= wp + 1'b1;
      if (deq) rp <= rp + 1'b1;
      case ({acc, deq})
        2'b10:   n <= n + 1'b1;
        2'b01:   n <= n - 1'b1;
        default: n <= n;
      endcase
      if (push && full) drop_cnt <= drop_cnt + 1'b1;
    end
  end

  // R6: a trigger into a full queue is counted and the queue stays full
  a_r6_reject: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (full && drop_cnt == $past(drop_cnt) + 1'b1));

  // R6: occupancy never passes the depth
  a_r6_depth: assert property (@(posedge clk) disable iff (rst)
    n <= (PW+1)'(DEPTH));
endmodule

// File: rtl/xtb_pkt_builder.sv
module xtb_pkt_builder
  import xtb_pkg::*;
#(
  parameter int XW        = 6,
  parameter int SLOT_HITS = 16,
  parameter int WORD_W    = 20,
  parameter int MAX_WORDS = 2000,
  localparam int IW       = $clog2(SLOT_HITS),
  localparam int CW       = $clog2(SLOT_HITS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              q_empty,
  input  logic [XW-1:0]     q_head,
  output logic              q_pop,
  output logic [XW-1:0]     rd_xing,
  output logic [IW-1:0]     rd_idx,
  input  logic [WORD_W-1:0] rd_word,
  input  logic [CW-1:0]     rd_cnt,
  input  logic              rd_ovf,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop
);
  localparam int HCAP = MAX_WORDS - 2;
  localparam logic [CW-1:0] HCAP_C = (HCAP > SLOT_HITS) ? CW'(SLOT_HITS) : CW'(HCAP);

  bstate_e       st;
  logic [XW-1:0] b_xing;
  logic [CW-1:0] b_cnt, b_send, idx;
  logic          b_ovf, b_trn, can_load;
  logic [15:0]   pw;

  always_comb begin
    q_pop    = (st == B_IDLE) && !q_empty;
    rd_xing  = (st == B_IDLE) ? q_head : b_xing;
    rd_idx   = idx[IW-1:0];
    can_load = !out_valid || out_ready;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= B_IDLE; out_valid <= 1'b0; out_data <= '0; out_sop <= 1'b0; out_eop <= 1'b0;
      b_xing <= '0; b_cnt <= '0; b_send <= '0; idx <= '0; b_ovf <= 1'b0; b_trn <= 1'b0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      case (st)
        B_IDLE: if (!q_empty) begin
          b_xing <= q_head;
          b_cnt  <= rd_cnt;
          b_ovf  <= rd_ovf;
          b_trn  <= rd_cnt > HCAP_C;
          b_send <= (rd_cnt > HCAP_C) ? HCAP_C : rd_cnt;
          st     <= B_HDR;
        end
        B_HDR: if (can_load) begin
          out_valid <= 1'b1; out_sop <= 1'b1; out_eop <= 1'b0;
          out_data  <= {HDR_TAG, {(WORD_W-4-XW){1'b0}}, b_xing};
          idx       <= '0;
          st        <= (b_send == '0) ? B_TRL : B_HITS;
        end
        B_HITS: if (can_load) begin
          out_valid <= 1'b1; out_sop <= 1'b0; out_eop <= 1'b0;
          out_data  <= rd_word;
          idx       <= idx + 1'b1;
          if (idx == b_send - 1'b1) st <= B_TRL;
        end
        default: if (can_load) begin
          out_valid <= 1'b1; out_sop <= 1'b0; out_eop <= 1'b1;
          out_data  <= {TRL_TAG, b_ovf, b_trn, {(WORD_W-12){1'b0}}, 6'(b_cnt)};
          st        <= B_IDLE;
        end
      endcase
    end
  end

  // word position inside the current packet, used by the cap check
  always_ff @(posedge clk) begin
    if (rst) pw <= '0;
    else if (out_valid && out_ready) pw <= out_sop ? 16'd1 : pw + 16'd1;
  end

  // R5: no packet grows past the cap
  a_r5_cap: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !out_sop) |-> (32'(pw) < MAX_WORDS));

  // R7: a stalled word is held unchanged
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

  // R4: a trailer carries the trailer tag, a header the header tag
  a_r4_frame_tags: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((!out_eop || out_data[WORD_W-1 -: 4] == TRL_TAG) &&
                   (!out_sop || out_data[WORD_W-1 -: 4] == HDR_TAG)));
endmodule

// File: rtl/xing_trig_buffer.sv
module xing_trig_buffer #(
  parameter int XW            = 6,
  parameter int SLOT_HITS     = 16,
  parameter int WORD_W        = 20,
  parameter int PKT_MAX_WORDS = 2000,
  parameter int TQ_DEPTH      = 4,
  parameter int DROP_W        = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [XW-1:0]     cur_xing,
  input  logic              hit_valid,
  output logic              hit_ready,
  input  logic [XW-1:0]     hit_xing,
  input  logic [WORD_W-1:0] hit_data,
  input  logic              trig_valid,
  input  logic [XW-1:0]     trig_xing,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic [DROP_W-1:0] trig_drop_cnt
);
  localparam int IW = $clog2(SLOT_HITS);
  localparam int CW = $clog2(SLOT_HITS + 1);

  logic              q_empty, q_pop, rd_ovf;
  logic [XW-1:0]     q_head, rd_xing;
  logic [IW-1:0]     rd_idx;
  logic [WORD_W-1:0] rd_word;
  logic [CW-1:0]     rd_cnt;

  xtb_slot_store #(.XW(XW), .SLOT_HITS(SLOT_HITS), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst(rst), .cur_xing(cur_xing),
    .hit_valid(hit_valid), .hit_ready(hit_ready), .hit_xing(hit_xing), .hit_data(hit_data),
    .rd_xing(rd_xing), .rd_idx(rd_idx), .rd_word(rd_word), .rd_cnt(rd_cnt), .rd_ovf(rd_ovf)
  );

  xtb_trig_fifo #(.DEPTH(TQ_DEPTH), .W(XW), .DROP_W(DROP_W)) u_tq (
    .clk(clk), .rst(rst), .push(trig_valid), .din(trig_xing), .pop(q_pop),
    .empty(q_empty), .head(q_head), .drop_cnt(trig_drop_cnt)
  );

  xtb_pkt_builder #(.XW(XW), .SLOT_HITS(SLOT_HITS), .WORD_W(WORD_W),
                    .MAX_WORDS(PKT_MAX_WORDS)) u_build (
    .clk(clk), .rst(rst), .q_empty(q_empty), .q_head(q_head), .q_pop(q_pop),
    .rd_xing(rd_xing), .rd_idx(rd_idx), .rd_word(rd_word), .rd_cnt(rd_cnt), .rd_ovf(rd_ovf),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop)
  );
endmodule

// File: tb/xing_trig_buffer_bench.sv
module xing_trig_buffer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAXW = 14;
  localparam int HCAP = MAXW - 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [5:0]  cur_xing = '0, hit_xing = '0, trig_xing = '0;
  logic        hit_valid = 1'b0, trig_valid = 1'b0, out_ready = 1'b0;
  logic [19:0] hit_data = '0;
  logic        hit_ready, out_valid, out_sop, out_eop;
  logic [19:0] out_data;
  logic [7:0]  trig_drop_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  xing_trig_buffer #(.PKT_MAX_WORDS(MAXW)) u_xing_trig_buffer (
    .clk(clk), .rst(rst), .cur_xing(cur_xing), .hit_valid(hit_valid), .hit_ready(hit_ready),
    .hit_xing(hit_xing), .hit_data(hit_data), .trig_valid(trig_valid), .trig_xing(trig_xing),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .trig_drop_cnt(trig_drop_cnt)
  );

  int checks = 0, errors = 0;
  int mcnt [64];
  bit movf [64];
  logic [19:0] mdat [64][16];
  logic [21:0] expq [$];
  int rdy_mode = 1;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // output ready driver
  initial forever begin
    @(negedge clk);
    case (rdy_mode)
      0: out_ready = 1'b0;
      1: out_ready = 1'b1;
      default: out_ready = 1'($urandom_range(0, 1));
    endcase
  end

  // output monitor: compares each handshaken word with the expected stream
  initial forever begin
    @(negedge clk);
    #1;
    if (!rst && out_valid && out_ready) begin
      if (expq.size() == 0) check("R4", "unexpected word", {10'b0, out_sop, out_eop, out_data}, 32'hFFFFFFFF);
      else begin
        logic [21:0] e;
        e = expq.pop_front();
        check("R4", "packet word", {10'b0, out_sop, out_eop, out_data}, {10'b0, e});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic step(input logic [5:0] nx, input bit hv, input logic [5:0] tag, input logic [19:0] d);
    @(negedge clk);
    if (nx != cur_xing) begin mcnt[nx] = 0; movf[nx] = 1'b0; end
    cur_xing = nx; hit_valid = hv; hit_xing = tag; hit_data = d;
    if (hv) begin
      if (mcnt[tag] < 16) begin mdat[tag][mcnt[tag]] = d; mcnt[tag]++; end
      else movf[tag] = 1'b1;
    end
  endtask

  task automatic quiet();
    @(negedge clk);
    hit_valid = 1'b0;
  endtask

  task automatic expect_pkt(input logic [5:0] x);
    int n, s;
    n = mcnt[x];
    s = (n > HCAP) ? HCAP : n;
    expq.push_back({2'b10, 4'hA, 10'b0, x});
    for (int i = 0; i < s; i++) expq.push_back({2'b00, mdat[x][i]});
    expq.push_back({2'b01, 4'hF, movf[x], 1'(n > HCAP), 8'b0, 6'(n)});
  endtask

  task automatic trig(input logic [5:0] x, input bit ok);
    @(negedge clk);
    trig_valid = 1'b1; trig_xing = x;
    if (ok) expect_pkt(x);
    @(negedge clk);
    trig_valid = 1'b0;
  endtask

  task automatic drain(input string req);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (expq.size() == 0) break;
    end
    repeat (4) @(negedge clk);
    check(req, "all expected words delivered", expq.size(), 0);
  endtask

  task automatic fill(input logic [5:0] x, input int nh);
    step(x, nh > 0, x, 20'($urandom));
    for (int i = 1; i < nh; i++) step(x, 1'b1, x, 20'($urandom));
    quiet();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin mcnt[i] = 0; movf[i] = 1'b0; end
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // R8 reset state
    check("R8", "hit_ready after reset", hit_ready, 1);
    check("R8", "out_valid after reset", out_valid, 0);
    check("R8", "drop count after reset", trig_drop_cnt, 0);
    trig(6'd5, 1'b1);          // R8: empty slot gives header + trailer
    drain("R8");

    // R1, R4: random fill with late hits, random backpressure (R7)
    for (int xv = 1; xv <= 20; xv++) begin
      int nh;
      nh = $urandom_range(0, 5);
      step(6'(xv), nh > 0, 6'(xv), 20'($urandom));
      for (int i = 1; i < nh; i++) begin
        int tg;
        tg = ($urandom_range(0, 3) == 0) ? xv - 1 : xv;
        step(6'(xv), 1'b1, 6'(tg), 20'($urandom));
      end
      quiet();
    end
    rdy_mode = 2;
    for (int k = 0; k < 8; k++) begin
      trig(6'($urandom_range(1, 20)), 1'b1);
      drain("R1");
    end

    // R5 boundary: 12 hits fit, 13 truncate; R2: 20 hits overflow
    rdy_mode = 1;
    fill(6'd30, 12);
    fill(6'd31, 13);
    fill(6'd32, 20);
    trig(6'd30, 1'b1); drain("R5");
    trig(6'd31, 1'b1); drain("R5");
    rdy_mode = 2;
    trig(6'd32, 1'b1); drain("R2");

    // R3: wrap the counter back to 1; new value and its hit in one cycle
    for (int v = 33; v < 65; v++) step(6'(v), 1'b0, 6'd0, 20'd0);
    step(6'd1, 1'b1, 6'd1, 20'hC0FFE);
    quiet();
    check("R3", "model count of reused slot", mcnt[1], 1);
    trig(6'd1, 1'b1); drain("R3");
    trig(6'd2, 1'b1); drain("R1");   // slot 2 still within the window

    // R6: stalled output, queue fills, sixth trigger discarded
    rdy_mode = 0;
    repeat (2) @(negedge clk);
    for (int k = 3; k < 8; k++) trig(6'(k), 1'b1);
    trig(6'd8, 1'b0);
    check("R6", "drop count after full queue", trig_drop_cnt, 1);
    check("R7", "word held under stall", out_valid, 1);
    rdy_mode = 2;
    drain("R6");

    // mixed random traffic
    for (int k = 0; k < 20; k++) begin
      logic [5:0] nx;
      nx = cur_xing + 6'd1;
      fill(nx, $urandom_range(0, 18));
      trig(6'(nx - 6'($urandom_range(0, 5))), 1'b1);
      drain("R4");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule